// File: doc/BRIEF.md
# Streaming Sobel Edge Thinner

The block takes a raster stream of grayscale pixels, one per clock, and returns a stream of thinned edge strengths of the same size. Line delay stores form a 3x3 neighbourhood around each pixel. The horizontal and vertical Sobel responses give a saturated gradient strength, and a direction is sorted into one of four bins using only integer compares and sign tests. A second 3x3 neighbourhood, built over the strength stream, keeps a pixel only when it is at least as strong as both of its neighbours along the gradient direction. Every other pixel becomes zero, which leaves edges one pixel wide.

The pipeline runs freely and has a fixed latency, so the output qualifier is the input qualifier delayed by a constant. A frame is `FRAME_H` lines of `LINE_W` pixels, sent with the input qualifier held high for the whole frame. Frames may follow each other with no idle cycles between them, or with any gap.

Top module: `sobel_nms_stream`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `mag_out` are 0. A frame cut short by reset produces no output afterwards.
- R2: For a pixel that is not on the border, the strength is min(255, |Ox| + |Oy|). Ox is the right column minus the left column with weights 1,2,1 (top to bottom). Oy is the bottom row minus the top row with weights 1,2,1 (left to right).
- R3: The direction code is 0 when 2·|Oy| < |Ox|. Otherwise it is 2 when 2·|Ox| < |Oy|. Otherwise it is 1 when Ox and Oy have equal sign flags (a zero counts as non-negative), and 3 when they do not.
- R4: The neighbour pairs are: code 0 uses left and right, code 2 uses above and below, code 1 uses above-left and below-right, and code 3 uses above-right and below-left. The centre strength is output when it is greater than or equal to both neighbours (ties are kept); otherwise the output is 0.
- R5: Pixels in the first or last row or column output 0. As neighbours in R4, their strength counts as 0.
- R6: `out_valid` equals `in_valid` delayed by exactly 2·LINE_W+4 clock edges. The result for frame pixel k appears that many edges after pixel k is taken in, in raster order.
- R7: `mag_out` is 0 whenever `out_valid` is low. Pixel values presented while `in_valid` is low have no effect on any output.
- R8: Consecutive frames may be sent with no idle cycle between them. Each such frame is still processed independently, at one pixel per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel qualifier, held high for a whole frame |
| in_pix | input | PIX_W | Grayscale input pixel |
| out_valid | output | 1 | Output pixel qualifier |
| mag_out | output | PIX_W | Thinned gradient strength |

## Verification
The bench builds the block with LINE_W=8 and FRAME_H=6. This gives a latency of 20 cycles and 48-pixel frames, so the line stores, the frame position counters and the frame wrap are all exercised many times per run. With frames this small, most interior pixels border the edge rows and columns, so the zero border and the zero neighbour rule take part in nearly every suppression decision. The frame patterns include steps, ramps with equal-strength ties, both diagonals, a single bright dot and noise. Together they drive every direction code and both the tie and the saturation cases, and some frames are sent back to back.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
    // Quantized gradient direction bins.
    typedef enum logic [1:0] {
        DIR_HORZ      = 2'd0,
        DIR_DIAG_SAME = 2'd1,
        DIR_VERT      = 2'd2,
        DIR_DIAG_OPP  = 2'd3
    } grad_dir_e;
endpackage

// File: rtl/tap_delay.sv
module tap_delay #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] sr [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else begin
            sr[0] <= din;
            for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
    end

    assign dout = sr[DEPTH-1];
endmodule

// File: rtl/win3x3.sv
module win3x3 #(
    parameter int DW     = 8,
    parameter int LINE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DW-1:0]             din,
    output logic [2:0][2:0][DW-1:0]   win
);
    localparam int ROWS = 3;

    logic [DW-1:0] line1, line2;
    logic [DW-1:0] row_s [ROWS];
    logic [DW-1:0] t1 [ROWS];
    logic [DW-1:0] t2 [ROWS];

    tap_delay #(.DW(DW), .DEPTH(LINE_W)) u_line1 (
        .clk(clk), .rst_n(rst_n), .din(din), .dout(line1)
    );
    tap_delay #(.DW(DW), .DEPTH(LINE_W)) u_line2 (
        .clk(clk), .rst_n(rst_n), .din(line1), .dout(line2)
    );

    // Row 0 is the oldest line (top), row 2 the newest (bottom).
    assign row_s[0] = line2;
    assign row_s[1] = line1;
    assign row_s[2] = din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < ROWS; g++) begin
                t1[g] <= '0;
                t2[g] <= '0;
            end
        end else begin
            for (int g = 0; g < ROWS; g++) begin
                t1[g] <= row_s[g];
                t2[g] <= t1[g];
            end
        end
    end

    // Column 0 is the oldest sample (left), column 2 the newest (right).
    always_comb begin
        for (int g = 0; g < ROWS; g++) win[g] = {row_s[g], t1[g], t2[g]};
    end
endmodule

// File: rtl/raster_pos.sv
module raster_pos #(
    parameter int LINE_W  = 16,
    parameter int FRAME_H = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic on_border
);
    localparam int CW = (LINE_W  > 1) ? $clog2(LINE_W)  : 1;
    localparam int RW = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;
    localparam logic [CW-1:0] COL_LAST = CW'(LINE_W - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(FRAME_H - 1);

    logic [CW-1:0] col;
    logic [RW-1:0] row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (adv) begin
            if (col == COL_LAST) begin
                col <= '0;
                row <= (row == ROW_LAST) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    assign on_border = (col == '0) || (col == COL_LAST) ||
                       (row == '0) || (row == ROW_LAST);
endmodule

// File: rtl/grad_dir.sv
module grad_dir
    import sobel_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [2:0][2:0][PIX_W-1:0] win,
    output logic [PIX_W-1:0]           mag,
    output grad_dir_e                  dir
);
    localparam int GW = PIX_W + 4;
    localparam int SW = GW + 1;

    function automatic logic signed [GW-1:0] ext(input logic [PIX_W-1:0] v);
        return $signed({4'd0, v});
    endfunction

    logic signed [GW-1:0] col_l, col_r, row_t, row_b, ox, oy;
    logic [GW-1:0] ax, ay;
    logic [SW-1:0] sum;

    always_comb begin
        col_l = ext(win[0][0]) + ext(win[1][0]) + ext(win[1][0]) + ext(win[2][0]);
        col_r = ext(win[0][2]) + ext(win[1][2]) + ext(win[1][2]) + ext(win[2][2]);
        row_t = ext(win[0][0]) + ext(win[0][1]) + ext(win[0][1]) + ext(win[0][2]);
        row_b = ext(win[2][0]) + ext(win[2][1]) + ext(win[2][1]) + ext(win[2][2]);
        ox    = col_r - col_l;
        oy    = row_b - row_t;
        ax    = ox[GW-1] ? $unsigned(-ox) : $unsigned(ox);
        ay    = oy[GW-1] ? $unsigned(-oy) : $unsigned(oy);
        sum   = {1'b0, ax} + {1'b0, ay};
        mag   = (|sum[SW-1:PIX_W]) ? '1 : sum[PIX_W-1:0];

        if ({ay, 1'b0} < {1'b0, ax})
            dir = DIR_HORZ;
        else if ({ax, 1'b0} < {1'b0, ay})
            dir = DIR_VERT;
        else if (ox[GW-1] == oy[GW-1])
            dir = DIR_DIAG_SAME;
        else
            dir = DIR_DIAG_OPP;
    end
endmodule

// File: rtl/sobel_nms_stream.sv
module sobel_nms_stream
    import sobel_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int LINE_W  = 16,
    parameter int FRAME_H = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic [PIX_W-1:0] mag_out
);
    localparam int CTR_DLY = LINE_W + 1;   // newest tap to window centre
    localparam int SD_W    = 3;            // valid + direction code

    // Stage 0: input capture, invalid cycles enter as zero.
    logic [PIX_W-1:0] p0;
    logic             v0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p0 <= '0;
            v0 <= 1'b0;
        end else begin
            p0 <= in_valid ? in_pix : '0;
            v0 <= in_valid;
        end
    end

    // Stage 1: pixel window, gradient, border masking.
    logic [2:0][2:0][PIX_W-1:0] pix_win;
    logic             vc, c_edge;
    logic [PIX_W-1:0] g_mag;
    grad_dir_e        g_dir;

    win3x3 #(.DW(PIX_W), .LINE_W(LINE_W)) u_pix_win (
        .clk(clk), .rst_n(rst_n), .din(p0), .win(pix_win)
    );
    tap_delay #(.DW(1), .DEPTH(CTR_DLY)) u_vc_dly (
        .clk(clk), .rst_n(rst_n), .din(v0), .dout(vc)
    );
    raster_pos #(.LINE_W(LINE_W), .FRAME_H(FRAME_H)) u_grad_pos (
        .clk(clk), .rst_n(rst_n), .adv(vc), .on_border(c_edge)
    );
    grad_dir #(.PIX_W(PIX_W)) u_grad (
        .win(pix_win), .mag(g_mag), .dir(g_dir)
    );

    logic [PIX_W-1:0] mag1;
    grad_dir_e        dir1;
    logic             v1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mag1 <= '0;
            dir1 <= DIR_HORZ;
            v1   <= 1'b0;
        end else begin
            mag1 <= (vc && !c_edge) ? g_mag : '0;
            dir1 <= g_dir;
            v1   <= vc;
        end
    end

    // Stage 2: strength window, direction aligned to its centre.
    logic [2:0][2:0][PIX_W-1:0] mag_win;
    logic [SD_W-1:0] sd_in, sd_out;
    logic            v2, n_edge;
    grad_dir_e       dir2;

    win3x3 #(.DW(PIX_W), .LINE_W(LINE_W)) u_mag_win (
        .clk(clk), .rst_n(rst_n), .din(mag1), .win(mag_win)
    );

    assign sd_in = {v1, dir1};
    tap_delay #(.DW(SD_W), .DEPTH(CTR_DLY)) u_sd_dly (
        .clk(clk), .rst_n(rst_n), .din(sd_in), .dout(sd_out)
    );
    assign v2   = sd_out[2];
    assign dir2 = grad_dir_e'(sd_out[1:0]);

    raster_pos #(.LINE_W(LINE_W), .FRAME_H(FRAME_H)) u_nms_pos (
        .clk(clk), .rst_n(rst_n), .adv(v2), .on_border(n_edge)
    );

    logic [PIX_W-1:0] centre, nb_a, nb_b;
    logic             keep;

    always_comb begin
        centre = mag_win[1][1];
        unique case (dir2)
            DIR_HORZ:      begin nb_a = mag_win[1][0]; nb_b = mag_win[1][2]; end
            DIR_VERT:      begin nb_a = mag_win[0][1]; nb_b = mag_win[2][1]; end
            DIR_DIAG_SAME: begin nb_a = mag_win[0][0]; nb_b = mag_win[2][2]; end
            DIR_DIAG_OPP:  begin nb_a = mag_win[0][2]; nb_b = mag_win[2][0]; end
            default:       begin nb_a = '0;            nb_b = '0;            end
        endcase
        keep = (centre >= nb_a) && (centre >= nb_b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            mag_out   <= '0;
        end else begin
            out_valid <= v2;
            mag_out   <= (v2 && !n_edge && keep) ? centre : '0;
        end
    end
endmodule

// File: rtl/sobel_nms_chk.sv
module sobel_nms_chk #(
    parameter int PIX_W   = 8,
    parameter int LINE_W  = 16,
    parameter int FRAME_H = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [PIX_W-1:0] mag_out
);
    localparam int LAT = 2 * LINE_W + 4;
    localparam int CW  = (LINE_W  > 1) ? $clog2(LINE_W)  : 1;
    localparam int RW  = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;

    logic [LAT:0]  vhist;
    logic [CW-1:0] oc;
    logic [RW-1:0] orow;
    logic          o_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vhist <= '0;
            oc    <= '0;
            orow  <= '0;
        end else begin
            vhist <= {vhist[LAT-1:0], in_valid};
            if (out_valid) begin
                if (oc == CW'(LINE_W - 1)) begin
                    oc   <= '0;
                    orow <= (orow == RW'(FRAME_H - 1)) ? '0 : orow + 1'b1;
                end else begin
                    oc <= oc + 1'b1;
                end
            end
        end
    end

    assign o_edge = (oc == '0) || (oc == CW'(LINE_W - 1)) ||
                    (orow == '0) || (orow == RW'(FRAME_H - 1));

    // R6
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vhist[LAT]);

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (mag_out == '0));

    // R5
    border_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && o_edge) |-> (mag_out == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && mag_out == '0));
endmodule

bind sobel_nms_stream sobel_nms_chk #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .FRAME_H(FRAME_H)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .out_valid(out_valid), .mag_out(mag_out)
);

// File: tb/sim_sobel_nms_stream.sv
module sim_sobel_nms_stream;
    localparam int W   = 8;
    localparam int H   = 6;
    localparam int LAT = 2 * W + 4;
    localparam int NF  = 8;
    // {pattern, idle gap after frame, probe row, probe col, probe expected}
    localparam int TBL [NF][5] = '{
        '{0, 0,  2,  3, 255},
        '{1, 3,  1,  1,  80},
        '{2, 0, -1, -1,   0},
        '{3, 0, -1, -1,   0},
        '{4, 5,  2,  4, 255},
        '{5, 0, -1, -1,   0},
        '{6, 2,  2,  2, 255},
        '{7, 0,  2,  2,   0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_pix = '0;
    logic       out_valid;
    logic [7:0] mag_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int out_cnt = 0;
    int start_cyc [NF];
    bit mon_on = 1'b0;

    sobel_nms_stream #(.PIX_W(8), .LINE_W(W), .FRAME_H(H)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .mag_out(mag_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int px(input int p, input int r, input int c);
        case (p)
            0: return (c >= 4) ? 200 : 0;
            1: return 10 * c;
            2: return (r + c >= 6) ? 100 : 0;
            3: return (c - r >= 2) ? 150 : 0;
            4: return (r >= 3) ? 90 : 0;
            5: return (r * 53 + c * 29 + r * c * 17 + 11) % 256;
            6: return (r == 2 && c == 3) ? 255 : 0;
            default: return 77;
        endcase
    endfunction

    function automatic bit edge_px(input int r, input int c);
        return (r == 0 || c == 0 || r == H - 1 || c == W - 1);
    endfunction

    function automatic int sx(input int p, input int r, input int c);
        return (px(p,r-1,c+1) + 2*px(p,r,c+1) + px(p,r+1,c+1))
             - (px(p,r-1,c-1) + 2*px(p,r,c-1) + px(p,r+1,c-1));
    endfunction

    function automatic int sy(input int p, input int r, input int c);
        return (px(p,r+1,c-1) + 2*px(p,r+1,c) + px(p,r+1,c+1))
             - (px(p,r-1,c-1) + 2*px(p,r-1,c) + px(p,r-1,c+1));
    endfunction

    function automatic int strength(input int p, input int r, input int c);
        int a, b, m;
        if (edge_px(r, c)) return 0;
        a = sx(p, r, c); b = sy(p, r, c);
        m = (a < 0 ? -a : a) + (b < 0 ? -b : b);
        return (m > 255) ? 255 : m;
    endfunction

    function automatic int expect_px(input int p, input int r, input int c);
        int a, b, aa, ab, m, n1, n2;
        if (edge_px(r, c)) return 0;
        a = sx(p, r, c); b = sy(p, r, c);
        aa = a < 0 ? -a : a; ab = b < 0 ? -b : b;
        m = strength(p, r, c);
        if (2 * ab < aa) begin
            n1 = strength(p, r, c-1); n2 = strength(p, r, c+1);
        end else if (2 * aa < ab) begin
            n1 = strength(p, r-1, c); n2 = strength(p, r+1, c);
        end else if ((a < 0) == (b < 0)) begin
            n1 = strength(p, r-1, c-1); n2 = strength(p, r+1, c+1);
        end else begin
            n1 = strength(p, r-1, c+1); n2 = strength(p, r+1, c-1);
        end
        return (m >= n1 && m >= n2) ? m : 0;
    endfunction

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (!out_valid) begin
                if (mag_out != 0) chk(1'b0, "R7 idle output", int'(mag_out), 0);
            end else begin
                int f, idx, r, c, p, e;
                string tag;
                f = out_cnt / (W * H);
                idx = out_cnt % (W * H);
                r = idx / W; c = idx % W;
                if (f >= NF) begin
                    chk(1'b0, "R6 unexpected output", out_cnt, NF * W * H);
                end else begin
                    p = TBL[f][0];
                    if (idx == 0) begin
                        tag = (f > 0 && TBL[f-1][1] == 0) ? "R8 back-to-back latency" : "R6 latency";
                        chk(cyc == start_cyc[f] + LAT + 1, tag, cyc, start_cyc[f] + LAT + 1);
                    end
                    e = expect_px(p, r, c);
                    if (edge_px(r, c)) tag = "R5 border";
                    else if (p == 2 || p == 3) tag = "R3 diagonal";
                    else if (p == 1 || p == 6) tag = "R4 suppression";
                    else tag = "R2 strength";
                    chk(int'(mag_out) == e, tag, int'(mag_out), e);
                    if (r == TBL[f][2] && c == TBL[f][3])
                        chk(int'(mag_out) == TBL[f][4], "R2 probe", int'(mag_out), TBL[f][4]);
                end
                out_cnt++;
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        chk(mag_out == 0, "R1 reset data", int'(mag_out), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        // Table walk: one frame per entry.
        for (int f = 0; f < NF; f++) begin
            for (int r = 0; r < H; r++) begin
                for (int c = 0; c < W; c++) begin
                    if (r == 0 && c == 0) start_cyc[f] = cyc;
                    in_valid = 1'b1;
                    in_pix = 8'(px(TBL[f][0], r, c));
                    @(negedge clk);
                end
            end
            for (int g = 0; g < TBL[f][1]; g++) begin
                in_valid = 1'b0;
                in_pix = 8'(g * 37 + 5);   // R7: ignored while not qualified
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        // R7: noise on the pixel input while idle must not create output.
        for (int i = 0; i < LAT + 10; i++) begin
            in_pix = 8'(i * 91 + 3);
            @(negedge clk);
        end
        chk(out_cnt == NF * W * H, "R6 output count", out_cnt, NF * W * H);
        mon_on = 1'b0;

        // R1: reset in the middle of a frame clears the pipeline.
        for (int i = 0; i < 30; i++) begin
            in_valid = 1'b1;
            in_pix = 8'(px(0, i / W, i % W));
            @(negedge clk);
        end
        chk(out_valid == 1'b1, "R6 partial frame running", int'(out_valid), 1);
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_pix = '0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 mid-frame reset valid", int'(out_valid), 0);
        chk(mag_out == 0, "R1 mid-frame reset data", int'(mag_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < LAT + 10; i++) begin
                @(negedge clk);
                if (out_valid || mag_out != 0) seen++;
            end
            chk(seen == 0, "R1 no stale output after reset", seen, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule